// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block holds the on/off state of 64 peripheral clock gates and exposes them to software through a small 32-bit register bus. The gates are grouped into two banks of 32. Software opens gates by writing ones to a bank's set register and closes them by writing ones to that bank's clear register. Zero bits in either word leave their gates alone, so drivers never need a read-modify-write sequence.

Each bank offers two read-only views. The request view shows what software last asked for. The status view shows the gate state that is actually applied. The status view trails the request by a fixed synchronizer delay, so software polls it until it matches before using a peripheral. Six gate positions have no gate behind them: they read as zero and ignore writes.

After reset every gate is closed except gate 2, the memory controller bus clock, which stays open.

Top module: `clk_gate_ctrl`

## Requirements
- R1: A write to the set register (offset 0x24 for gates 0–31, 0x34 for gates 32–63) latches a request for every bit written as 1. Bits written as 0 change nothing.
- R2: A write to the clear register (offset 0x28 for bank 0, 0x38 for bank 1) drops the request for every bit written as 1. Bits written as 0 change nothing.
- R3: Gate ID n belongs to bank n/32 at bit position n mod 32. Output `gate_en[n]` drives gate n.
- R4: The request views at offsets 0x2C (bank 0) and 0x3C (bank 1) show the new request right after the clock edge that takes the write.
- R5: `gate_en`, and the status views at offsets 0x30 (bank 0) and 0x40 (bank 1), follow the request exactly two clock edges after the request changes. They do not change before then.
- R6: Reserved IDs 32, 33, 34, 35, 55 and 57 always read 0 in both views, keep their `gate_en` bits at 0, and ignore set writes.
- R7: After reset only gate 2 is open. Its request bit and its status bit both read 1, and every other bit reads 0.
- R8: Reads of unmapped offsets return 0. Writes to unmapped offsets or to the status views change no request.
- R9: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| gate_en | output | 64 | Applied gate enables, one per gate ID |

## Verification
A new set or clear can land while an earlier change to the same bank is still moving through the two-stage synchronizer. In that case the request view and the status view disagree on purpose. The bench provokes this with back-to-back writes and with status reads taken at the edge right after a write and at the edge after that. At those points the status must still show the old state while the request already shows the new one. From the third sample on, every bit must match the request model, which is built only from the written words and the reserved-ID list.

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int BANKS       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_OFF    = 'h24,
  parameter int BANK_STRIDE = 'h10,
  parameter logic [BANKS*DATA_W-1:0] RSV_MASK   = 64'h0280_000F_0000_0000,
  parameter logic [BANKS*DATA_W-1:0] RESET_OPEN = 64'h0000_0000_0000_0004
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [BANKS*DATA_W-1:0] gate_en
);
  localparam int GATES = BANKS * DATA_W;
  localparam logic [GATES-1:0] RST_REQ = RESET_OPEN & ~RSV_MASK;

  logic [GATES-1:0]  req_q, set_v, clr_v, req_d;
  logic [GATES-1:0]  sync_q [SYNC_STAGES];
  logic [DATA_W-1:0] rd_v   [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int OFF_SET = BASE_OFF + b * BANK_STRIDE;
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_SET + 4);
    localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(OFF_SET + 8);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_SET + 12);

    assign set_v[b*DATA_W +: DATA_W] = (bus_wr && bus_addr == A_SET) ? bus_wdata : '0;
    assign clr_v[b*DATA_W +: DATA_W] = (bus_wr && bus_addr == A_CLR) ? bus_wdata : '0;
    assign rd_v[b] = !bus_rd            ? '0 :
                     (bus_addr == A_REQ) ? req_q[b*DATA_W +: DATA_W] :
                     (bus_addr == A_STS) ? gate_en[b*DATA_W +: DATA_W] : '0;

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SET) |=>
        ((req_q[b*DATA_W +: DATA_W] & $past(bus_wdata & ~RSV_MASK[b*DATA_W +: DATA_W]))
          == $past(bus_wdata & ~RSV_MASK[b*DATA_W +: DATA_W]))); // R1
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CLR) |=>
        ((req_q[b*DATA_W +: DATA_W] & $past(bus_wdata)) == '0)); // R2
  end

  assign req_d = (req_q | set_v) & ~clr_v & ~RSV_MASK;

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < BANKS; b++) bus_rdata = bus_rdata | rd_v[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= RST_REQ;
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= RST_REQ;
    end else begin
      req_q     <= req_d;
      sync_q[0] <= req_q;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign gate_en = sync_q[SYNC_STAGES-1];

  logic [7:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q < 8'(SYNC_STAGES)) warm_q <= warm_q + 8'd1;
  end

  AST_STATUS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 8'(SYNC_STAGES)) |-> (gate_en == $past(req_q, SYNC_STAGES))); // R5
  AST_RSV_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_en & RSV_MASK) == '0) && ((req_q & RSV_MASK) == '0)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(req_q)); // R8
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/tb_clk_gate_ctrl.sv
module tb_clk_gate_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] gate_en;

  int errors = 0, checks = 0;
  logic [63:0] m_req, m_sts;

  clk_gate_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_en(gate_en));

  always #2.5 clk = ~clk;

  function automatic logic [63:0] rsv_mask();
    logic [63:0] m = '0;
    m[32] = 1; m[33] = 1; m[34] = 1; m[35] = 1; m[55] = 1; m[57] = 1;
    return m;
  endfunction

  function automatic logic [63:0] model_write(logic [63:0] r, logic [7:0] a, logic [31:0] d);
    case (a)
      8'h24: r[31:0]  = r[31:0]  | d;
      8'h28: r[31:0]  = r[31:0]  & ~d;
      8'h34: r[63:32] = r[63:32] | d;
      8'h38: r[63:32] = r[63:32] & ~d;
      default: ;
    endcase
    return r & ~rsv_mask();
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a, logic [63:0] rq, logic [63:0] st);
    case (a)
      8'h2C: return rq[31:0];
      8'h3C: return rq[63:32];
      8'h30: return st[31:0];
      8'h40: return st[63:32];
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    m_req = model_write(m_req, a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_rd = 1; bus_addr = a; #0.5; v = bus_rdata; bus_rd = 0; #0.1;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    rd(8'h2C, v); check({tag, " R4 req0"}, {32'h0, v}, {32'h0, m_req[31:0]});
    rd(8'h3C, v); check({tag, " R4 req1"}, {32'h0, v}, {32'h0, m_req[63:32]});
    rd(8'h30, v); check({tag, " R5 sts0"}, {32'h0, v}, {32'h0, m_sts[31:0]});
    rd(8'h40, v); check({tag, " R5 sts1"}, {32'h0, v}, {32'h0, m_sts[63:32]});
    check({tag, " R3 gate_en"}, gate_en, m_sts);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] old;
    logic [7:0] offs [9];
    int unsigned seed;
    offs = '{8'h24, 8'h28, 8'h34, 8'h38, 8'h2C, 8'h30, 8'h3C, 8'h40, 8'h1C};
    seed = $urandom(32'h5eed);
    m_req = 64'h4; m_sts = 64'h4;
    #12 rst_n = 1;
    @(negedge clk);
    check("R7 reset gate_en", gate_en, 64'h4);
    check_all("R7 reset");

    #1; v = bus_rdata; check("R9 idle rdata", {32'h0, v}, 64'h0);

    old = m_sts;
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h2C, v); check("R1/R4 set bank0 req", {32'h0, v}, 64'hFFFF_FFFF);
    rd(8'h30, v); check("R5 status lags edge1", {32'h0, v}, {32'h0, old[31:0]});
    @(negedge clk);
    rd(8'h30, v); check("R5 status lags edge2", {32'h0, v}, {32'h0, old[31:0]});
    check("R5 gate_en lags", gate_en, old);
    @(negedge clk); m_sts = m_req;
    check_all("R5 settled");

    wr(8'h34, 32'hFFFF_FFFF); @(negedge clk); @(negedge clk); m_sts = m_req;
    check("R6 reserved bank1", {32'h0, m_req[63:32]}, 64'hFD7F_FFF0);
    check_all("R6 bank1 set");

    wr(8'h28, 32'h0000_00F0); @(negedge clk); @(negedge clk); m_sts = m_req;
    check("R2 clear bits", gate_en[7:0], 64'h0F);
    check_all("R2 clear");

    wr(8'h38, 32'hFFFF_FFFF); wr(8'h34, 32'h0000_2000);
    @(negedge clk); @(negedge clk); m_sts = m_req;
    check("R3 id45 open", {63'h0, gate_en[45]}, 64'h1);
    check("R3 id44 closed", {63'h0, gate_en[44]}, 64'h0);

    old = m_req;
    wr(8'h30, 32'h0); wr(8'h40, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF); wr(8'h3C, 32'h0);
    @(negedge clk); @(negedge clk); m_sts = m_req;
    check("R8 ignored writes", m_req, old);
    check_all("R8 ignored");
    rd(8'h44, v); check("R8 unmapped read", {32'h0, v}, 64'h0);
    rd(8'h00, v); check("R8 unmapped read 0", {32'h0, v}, 64'h0);

    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = offs[$urandom % 9];
      d = $urandom;
      wr(a, d);
      if ((i % 4) == 0) wr(offs[$urandom % 4], $urandom);
      @(negedge clk); @(negedge clk); m_sts = m_req;
      check_all("R1 R2 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule